// File: doc/BRIEF.md
# Framed Serial Converter Command Receiver

This block is the digital front-end of an eight-channel, 10-bit converter. A host sends 16-bit command words over three wires: a serial clock, a serial data line and an active-low frame select. While the frame select is low, the block samples one data bit on each falling edge of the serial clock, most significant bit first. After the sixteenth bit it writes the 10-bit code into the input register of the channel that the word names. Hosts that can only move eight bits at a time may split a word into two bursts with a pause between them. The frame select stays low through the pause, and the bit count carries across it.

Each channel holds two registers. The input register takes new codes. The output latch drives the converter. A low level on the load strobe copies every input register into its output latch. A host can fill several channels and then update them together with one strobe. If the strobe is tied low, the addressed channel's output follows each completed word. A low level on the clear input forces every input register and every output latch to zero code.

All serial and control inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block detects edges in the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_frontend`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every channel of `dac_code` reads zero from the next cycle on.
- R2: A word is 16 bits, sampled on falling serial clock edges while `frame_n` is low, first bit = bit 15. Bits [14:12] select channel 0..7, and bits [9:0] give the code. Channel c appears on `dac_code[c*10 +: 10]`.
- R3: While `load_n` is high, completed words change only the input registers, and `dac_code` holds its value.
- R4: A low level on `load_n` copies all eight input registers to the outputs together, so several channels written earlier appear at the same time.
- R5: With `load_n` held low, the addressed channel's output shows the new code a few system clocks after the sixteenth falling edge, without any strobe activity.
- R6: A word sent as two 8-bit bursts, with an idle pause between them and `frame_n` low throughout, is received the same as a continuous word.
- R7: If `frame_n` rises before 16 bits have arrived, the partial word is dropped and no register changes.
- R8: Falling edges after the sixteenth in the same frame are ignored. The word already received is the one that is written.
- R9: Bits 15, 11 and 10 of a word have no effect on the channel selected or the code written.
- R10: A low level on `clear_n` zeroes every input register and every output latch. A load strobe after a clear therefore drives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idles high, data sampled on its falling edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| frame_n | input | 1 | Active-low frame select |
| load_n | input | 1 | Active-low transfer of input registers to output latches |
| clear_n | input | 1 | Active-low clear of all registers to zero code |
| dac_code | output | 80 | Eight latched 10-bit codes, channel c at bits c*10+9..c*10 |

## Verification
The bench covers the edges of a frame.

- **Split word.** It sends a word as two bursts with a long pause between them. A receiver that restarts its count on the pause would write a misaligned code.
- **Short frame.** It closes a frame after twelve bits. A receiver that did not discard partial words would overwrite a channel.
- **Long frame.** It sends twenty bits in one frame. A receiver that kept shifting after sixteen bits would pick the wrong channel or code.
- **Ignored bits.** It sets the three unused bits to ones, which exposes a channel-select or code field taken from the wrong position.
- **Buffering and clear.** It writes channels while the strobe is high and checks that the outputs do not move. It then clears and strobes, and checks for zero outputs. This exposes latches that are transparent when they should hold, and a clear that reaches only one register stage.

// File: rtl/sdac_pkg.sv
// Shared sizing for the framed serial converter front-end.
// Assumes one channel-select field located just below the top bit of the word.
package sdac_pkg;
    localparam int WORD_W  = 16;   // bits per command word
    localparam int CODE_W  = 10;   // converter code width
    localparam int NUM_CH  = 8;    // number of channels
    localparam int SEL_LSB = 12;   // lowest bit of the channel field
endpackage

// File: rtl/sdac_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes the bits are independent levels; no coherence between bits is implied.
module sdac_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first flop samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d_async;
                end
            end else begin : g_next
                // later flops resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
// Frame receiver: detects falling serial clock edges in the system clock
// domain, shifts data MSB first and flags a completed word for one cycle.
// Assumes synchronized inputs and a system clock >= 4x the serial clock.
// The count is kept while frame_s stays low, so pauses inside a frame are harmless.
module sdac_shifter #(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          dat_s,
    input  logic          frame_s,
    output logic          word_done,
    output logic [WW-1:0] word
);
    localparam int CNTW = $clog2(WW + 1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(WW);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(WW - 1);

    logic            sclk_d;
    logic            fall;
    logic [CNTW-1:0] cnt;
    logic [WW-1:0]   sreg;

    // delayed serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    assign fall = sclk_d & ~sclk_s;

    // shift bits, count them, and flag the sixteenth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sreg      <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (frame_s) begin
                cnt <= '0;
            end else if (fall && (cnt < CNT_FULL)) begin
                sreg <= {sreg[WW-2:0], dat_s};
                cnt  <= cnt + 1'b1;
                if (cnt == CNT_LAST) word_done <= 1'b1;
            end
        end
    end

    assign word = sreg;
endmodule

// File: rtl/sdac_regbank.sv
// Double-buffered channel storage: one input register and one output latch
// per channel. The output latches copy the input registers while load_s is low.
// Clear and reset zero both stages. Assumes synchronized load_s and clr_s.
module sdac_regbank #(
    parameter int NCH  = 8,
    parameter int CW   = 10,
    parameter int SELW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_s,
    input  logic              load_s,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [CW-1:0]     wr_code,
    output logic [NCH*CW-1:0] dac_code
);
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic [CW-1:0] in_r;
            logic [CW-1:0] out_r;

            // input register takes words addressed to this channel
            always_ff @(posedge clk) begin
                if (!rst_n || !clr_s)                           in_r <= '0;
                else if (wr_en && (wr_sel == SELW'(c)))         in_r <= wr_code;
            end

            // output latch follows the input register while load is low
            always_ff @(posedge clk) begin
                if (!rst_n || !clr_s) out_r <= '0;
                else if (!load_s)     out_r <= in_r;
            end

            assign dac_code[c*CW +: CW] = out_r;
        end
    endgenerate
endmodule

// File: rtl/sdac_frontend.sv
// Top of the framed serial converter front-end. It synchronizes the five
// asynchronous inputs, receives 16-bit words and stores the selected code
// in a double-buffered bank. Assumes clk runs at least 4x ser_clk.
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int NCH         = NUM_CH,
    parameter int CW          = CODE_W,
    parameter int WW          = WORD_W,
    parameter int SEL_LO      = SEL_LSB,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              frame_n,
    input  logic              load_n,
    input  logic              clear_n,
    output logic [NCH*CW-1:0] dac_code
);
    localparam int SELW = $clog2(NCH);

    logic          sclk_q, dat_q, frame_q, load_q, clr_q;
    logic          word_done;
    logic [WW-1:0] word;
    logic          unused_bits;

    // bring all asynchronous inputs into the clk domain (idle levels on reset)
    sdac_sync #(
        .W       (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b10111)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_clk, ser_dat, frame_n, load_n, clear_n}),
        .q_sync  ({sclk_q, dat_q, frame_q, load_q, clr_q})
    );

    sdac_shifter #(
        .WW (WW)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_q),
        .dat_s     (dat_q),
        .frame_s   (frame_q),
        .word_done (word_done),
        .word      (word)
    );

    sdac_regbank #(
        .NCH  (NCH),
        .CW   (CW),
        .SELW (SELW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_s    (clr_q),
        .load_s   (load_q),
        .wr_en    (word_done),
        .wr_sel   (word[SEL_LO +: SELW]),
        .wr_code  (word[CW-1:0]),
        .dac_code (dac_code)
    );

    // bits outside the channel and code fields are don't-care
    assign unused_bits = ^{word[WW-1], word[SEL_LO-1:CW]};
endmodule

// File: rtl/sdac_frontend_chk.sv
// Property checker for sdac_frontend, attached by bind below.
module sdac_frontend_chk #(
    parameter int NCH = 8,
    parameter int CW  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_q,
    input logic              clr_q,
    input logic              frame_q,
    input logic              word_done,
    input logic [NCH*CW-1:0] dac_code
);
    // reset drives every output to zero code
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0));

    // outputs hold while the load strobe is inactive
    assert_hold_unloaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q && clr_q) |=> $stable(dac_code));

    // a closed frame never completes a word
    assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q |=> !word_done);

    // clear forces zero code on all channels
    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_q |=> (dac_code == '0));
endmodule

bind sdac_frontend sdac_frontend_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_q    (load_q),
    .clr_q     (clr_q),
    .frame_q   (frame_q),
    .word_done (word_done),
    .dac_code  (dac_code)
);

// File: tb/sdac_frontend_test.sv
module sdac_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;      // system clocks per serial half period
    localparam int NCH        = 8;
    localparam int CW         = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1, ser_dat = 1'b0, frame_n = 1'b1, load_n = 1'b1, clear_n = 1'b1;
    logic [NCH*CW-1:0] dac_code;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [CW-1:0] in_m  [NCH];
    logic [CW-1:0] out_m [NCH];

    sdac_frontend uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .frame_n(frame_n), .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input int ch, input logic [CW-1:0] code);
        return {1'b0, 3'(ch), 2'b00, code};
    endfunction

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            n_chk++;
            if (dac_code[c*CW +: CW] !== out_m[c]) begin
                n_bad++;
                $display("FAIL %s ch%0d actual=%h expected=%h", req, c,
                         dac_code[c*CW +: CW], out_m[c]);
            end
        end
    endtask

    task automatic send(input logic [31:0] pat, input int nbits, input bit pause);
        frame_n = 1'b0;
        wait_clks(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = pat[i];
            wait_clks(HALF);
            ser_clk = 1'b0;
            wait_clks(HALF);
            ser_clk = 1'b1;
            if (pause && i == nbits - 8) wait_clks(40);
        end
        wait_clks(HALF);
        frame_n = 1'b1;
        wait_clks(12);
    endtask

    // model a complete word landing in the input bank
    task automatic model_word(input int ch, input logic [CW-1:0] code);
        in_m[ch] = code;
        if (load_n == 1'b0) out_m = in_m;
    endtask

    task automatic t_reset;
        check_all("R1");
    endtask

    task automatic t_auto;
        load_n = 1'b0;
        wait_clks(6);
        send({16'h0, mk(3, 10'h2A5)}, 16, 1'b0); model_word(3, 10'h2A5);
        check_all("R5");
        send({16'h0, mk(7, 10'h3FF)}, 16, 1'b0); model_word(7, 10'h3FF);
        send({16'h0, mk(0, 10'h001)}, 16, 1'b0); model_word(0, 10'h001);
        check_all("R2");
    endtask

    task automatic t_buffered;
        load_n = 1'b1;
        wait_clks(6);
        send({16'h0, mk(1, 10'h155)}, 16, 1'b0); model_word(1, 10'h155);
        send({16'h0, mk(2, 10'h0AA)}, 16, 1'b0); model_word(2, 10'h0AA);
        check_all("R3");
        load_n = 1'b0;
        wait_clks(6);
        load_n = 1'b1;
        out_m = in_m;
        wait_clks(6);
        check_all("R4");
    endtask

    task automatic t_bursts;
        load_n = 1'b0;
        wait_clks(6);
        send({16'h0, mk(5, 10'h1C3)}, 16, 1'b1); model_word(5, 10'h1C3);
        check_all("R6");
    endtask

    task automatic t_short;
        send({16'h0, mk(4, 10'h3FF)} >> 4, 12, 1'b0);
        check_all("R7");
    endtask

    task automatic t_extra;
        send({12'h0, mk(6, 10'h123), 4'hF}, 20, 1'b0); model_word(6, 10'h123);
        check_all("R8");
    endtask

    task automatic t_ignored;
        send({16'h0, 1'b1, 3'd2, 2'b11, 10'h077}, 16, 1'b0); model_word(2, 10'h077);
        check_all("R9");
    endtask

    task automatic t_clear;
        load_n = 1'b1;
        wait_clks(6);
        send({16'h0, mk(0, 10'h200)}, 16, 1'b0); model_word(0, 10'h200);
        clear_n = 1'b0;
        wait_clks(6);
        clear_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin in_m[c] = '0; out_m[c] = '0; end
        wait_clks(6);
        check_all("R10");
        load_n = 1'b0;
        wait_clks(6);
        load_n = 1'b1;
        wait_clks(6);
        check_all("R10");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin in_m[c] = '0; out_m[c] = '0; end
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset;
        t_auto;
        t_buffered;
        t_bursts;
        t_short;
        t_extra;
        t_ignored;
        t_clear;
        done = 1'b1;
        summary;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary;
            $finish;
        end
    end
endmodule